// File: doc/BRIEF.md
# Tagged Register File

This block holds the working registers of a 64-bit datapath. Each entry stores a data word and three tag bits beside it: an invalid-value flag, a written-since-clear flag and an even-parity bit. Two read ports return data and tags combinationally. One write port updates an entry on the clock edge. A small combine stage derives the invalid flag for an operation's result from the two operands being read.

Register numbers are seven bits wide, which gives 128 entries. Entry zero is fixed: it reads as zero with clear tags, and it cannot be written. The written-since-clear flag of any entry can be reset through a separate clear input. A save sequencer can then skip registers that have not been touched. Every read recomputes parity over the returned data and compares it with the stored bit. Each port reports a mismatch on its own error output.

Top module: `tagged_regfile`

## Requirements
- R1: After reset, every entry reads data 0, invalid flag 0, written flag 0, parity bit 0 and error flag 0.
- R2: A write to a nonzero address stores the 64-bit data and the supplied invalid flag, and sets the entry's written flag. All three are visible on reads from the following cycle onward.
- R3: A read from the address being written in the same cycle returns the value held before that write.
- R4: Address 0 always reads data 0, with the invalid, written and parity flags at 0. Writes and written-flag clears to address 0 have no effect.
- R5: The stored parity bit is the XOR of all 64 data bits of the write (even parity over data only), and each read port presents it on its parity output.
- R6: A port's parity-error output is 1 exactly when the addressed entry's stored parity bit differs from the XOR of its stored data. Otherwise it is 0.
- R7: A clear request resets the written flag of the addressed entry and leaves its data and invalid flag unchanged. When a write and a clear target the same entry in one cycle, the written flag ends up set.
- R8: The result invalid output is 1 whenever the invalid flag on read port A or read port B is 1, and 0 when both are 0.
- R9: The two read ports are independent: each returns the contents of its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 7 | Write register number |
| wr_data | input | 64 | Write data |
| wr_nan | input | 1 | Invalid flag stored with the write |
| clr_en | input | 1 | Written-flag clear request |
| clr_addr | input | 7 | Register whose written flag is cleared |
| rd_a_addr | input | 7 | Port A register number |
| rd_a_data | output | 64 | Port A data |
| rd_a_nan | output | 1 | Port A invalid flag |
| rd_a_dirty | output | 1 | Port A written flag |
| rd_a_par | output | 1 | Port A stored parity bit |
| rd_a_perr | output | 1 | Port A parity mismatch |
| rd_b_addr | input | 7 | Port B register number |
| rd_b_data | output | 64 | Port B data |
| rd_b_nan | output | 1 | Port B invalid flag |
| rd_b_dirty | output | 1 | Port B written flag |
| rd_b_par | output | 1 | Port B stored parity bit |
| rd_b_perr | output | 1 | Port B parity mismatch |
| res_nan | output | 1 | Invalid flag for a result combined from ports A and B |

## Verification
Some properties are checked on every cycle. Entry zero must read as clean zero, stored parity must agree with the data on both ports, an invalid operand must give an invalid result, a write must appear at its address on the next cycle, and a clear must leave the entry's written flag low. Other behaviour shows only in the bench's scenarios: the all-zero state after reset, the old value returned during a same-cycle write, data and invalid flags surviving a clear, write-over-clear precedence on one address, and full address sweeps on both ports with independent patterns.

// File: rtl/trf_pkg.sv
`timescale 1ns/1ps
// Shared types for the tagged register file.
// Assumes all modules take their widths from the parameters below.
package trf_pkg;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 7;

    // Tag bits kept beside each data word; none are covered by parity.
    typedef struct packed {
        logic nan;
        logic dirty;
        logic par;
    } trf_tag_t;
endpackage

// File: rtl/trf_storage.sv
`timescale 1ns/1ps
// Entry array with tags. Writes land on the clock edge; entry 0 is never
// written. Assumes synchronous active-low reset and a single write port.
module trf_storage #(
    parameter int DATA_W = trf_pkg::DATA_W,
    parameter int ADDR_W = trf_pkg::ADDR_W,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  wr_nan,
    input  logic                  clr_en,
    input  logic [ADDR_W-1:0]     clr_addr,
    output logic [DATA_W-1:0]     data_q [NREG],
    output trf_pkg::trf_tag_t     tag_q  [NREG]
);
    logic wr_live;
    logic clr_live;

    // Qualify requests: address 0 is read-only.
    always_comb begin
        wr_live  = wr_en  && (wr_addr  != '0);
        clr_live = clr_en && (clr_addr != '0);
    end

    // Update data and tags; a write beats a clear on the same entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                data_q[i] <= '0;
                tag_q[i]  <= '0;
            end
        end else begin
            if (clr_live)
                tag_q[clr_addr].dirty <= 1'b0;
            if (wr_live) begin
                data_q[wr_addr]      <= wr_data;
                tag_q[wr_addr].nan   <= wr_nan;
                tag_q[wr_addr].dirty <= 1'b1;
                tag_q[wr_addr].par   <= ^wr_data;
            end
        end
    end
endmodule

// File: rtl/trf_read_port.sv
`timescale 1ns/1ps
// One combinational read port. Forces entry 0 to clean zero and compares
// the stored parity with the data read back. Assumes the array is registered.
module trf_read_port #(
    parameter int DATA_W = trf_pkg::DATA_W,
    parameter int ADDR_W = trf_pkg::ADDR_W,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic [DATA_W-1:0]     data_q [NREG],
    input  trf_pkg::trf_tag_t     tag_q  [NREG],
    input  logic [ADDR_W-1:0]     addr,
    output logic [DATA_W-1:0]     data,
    output trf_pkg::trf_tag_t     tag,
    output logic                  perr
);
    // Select the entry and check its parity.
    always_comb begin
        if (addr == '0) begin
            data = '0;
            tag  = '0;
            perr = 1'b0;
        end else begin
            data = data_q[addr];
            tag  = tag_q[addr];
            perr = (^data_q[addr]) ^ tag_q[addr].par;
        end
    end
endmodule

// File: rtl/trf_tag_combine.sv
`timescale 1ns/1ps
// Derives the result invalid flag from two operand tags.
// Assumes operands come straight from the read ports.
module trf_tag_combine (
    input  trf_pkg::trf_tag_t op_a,
    input  trf_pkg::trf_tag_t op_b,
    output logic              res_nan
);
    // An invalid operand makes the whole result invalid.
    always_comb res_nan = op_a.nan | op_b.nan;
endmodule

// File: rtl/tagged_regfile.sv
`timescale 1ns/1ps
// Tagged register file top: storage, two read ports and the operand
// tag combine. Assumes one write and one clear request per cycle at most.
module tagged_regfile #(
    parameter int DATA_W = trf_pkg::DATA_W,
    parameter int ADDR_W = trf_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_nan,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_nan,
    output logic              rd_a_dirty,
    output logic              rd_a_par,
    output logic              rd_a_perr,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_nan,
    output logic              rd_b_dirty,
    output logic              rd_b_par,
    output logic              rd_b_perr,
    output logic              res_nan
);
    localparam int NREG  = 1 << ADDR_W;
    localparam int NPORT = 2;

    logic [DATA_W-1:0]  data_q [NREG];
    trf_pkg::trf_tag_t  tag_q  [NREG];

    logic [ADDR_W-1:0]  p_addr [NPORT];
    logic [DATA_W-1:0]  p_data [NPORT];
    trf_pkg::trf_tag_t  p_tag  [NPORT];
    logic               p_perr [NPORT];

    trf_storage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_nan(wr_nan),
        .clr_en(clr_en), .clr_addr(clr_addr),
        .data_q(data_q), .tag_q(tag_q)
    );

    // Route port addresses into the port array.
    always_comb begin
        p_addr[0] = rd_a_addr;
        p_addr[1] = rd_b_addr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        trf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
            .data_q(data_q), .tag_q(tag_q), .addr(p_addr[p]),
            .data(p_data[p]), .tag(p_tag[p]), .perr(p_perr[p])
        );
    end

    trf_tag_combine u_comb (.op_a(p_tag[0]), .op_b(p_tag[1]), .res_nan(res_nan));

    // Flatten port results onto the named outputs.
    always_comb begin
        rd_a_data  = p_data[0];
        rd_a_nan   = p_tag[0].nan;
        rd_a_dirty = p_tag[0].dirty;
        rd_a_par   = p_tag[0].par;
        rd_a_perr  = p_perr[0];
        rd_b_data  = p_data[1];
        rd_b_nan   = p_tag[1].nan;
        rd_b_dirty = p_tag[1].dirty;
        rd_b_par   = p_tag[1].par;
        rd_b_perr  = p_perr[1];
    end
endmodule

// File: rtl/trf_checker.sv
`timescale 1ns/1ps
// Port-level properties of the tagged register file, bound to the top.
module trf_checker #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_nan,
    input logic              clr_en,
    input logic [ADDR_W-1:0] clr_addr,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              rd_a_nan,
    input logic              rd_a_dirty,
    input logic              rd_a_par,
    input logic              rd_a_perr,
    input logic [ADDR_W-1:0] rd_b_addr,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              rd_b_nan,
    input logic              rd_b_dirty,
    input logic              rd_b_par,
    input logic              rd_b_perr,
    input logic              res_nan
);
    AST_ZERO_ENTRY_A: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_addr == '0 |-> (rd_a_data == '0 && !rd_a_nan && !rd_a_dirty && !rd_a_par)); // R4
    AST_ZERO_ENTRY_B: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_addr == '0 |-> (rd_b_data == '0 && !rd_b_nan && !rd_b_dirty && !rd_b_par)); // R4
    AST_PARITY_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_par == ^rd_a_data) && !rd_a_perr); // R6
    AST_PARITY_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_par == ^rd_b_data) && !rd_b_perr); // R6
    AST_NAN_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_nan || rd_b_nan) |-> res_nan); // R8
    AST_NAN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_a_nan && !rd_b_nan) |-> !res_nan); // R8
    AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0) |=> (rd_a_addr != $past(wr_addr)) ||
            (rd_a_data == $past(wr_data) && rd_a_nan == $past(wr_nan) && rd_a_dirty)); // R2
    AST_CLEAR_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(wr_en && wr_addr == clr_addr)) |=>
            (rd_a_addr != $past(clr_addr)) || !rd_a_dirty); // R7
endmodule

bind tagged_regfile trf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_tagged_regfile.sv
`timescale 1ns/1ps
// Self-checking bench: full address sweeps on both ports against a model.
module sim_tagged_regfile;
    localparam int NREG = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_nan = 1'b0, clr_en = 1'b0;
    logic [6:0]  wr_addr = '0, clr_addr = '0, rd_a_addr = '0, rd_b_addr = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_a_data, rd_b_data;
    logic        rd_a_nan, rd_a_dirty, rd_a_par, rd_a_perr;
    logic        rd_b_nan, rd_b_dirty, rd_b_par, rd_b_perr, res_nan;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [63:0] m_data [NREG];
    logic        m_nan  [NREG];
    logic        m_dirty[NREG];

    always #2.5 clk = ~clk;

    tagged_regfile u0 (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(int i, int s);
        logic [63:0] p = 64'h9E3779B97F4A7C15 * 64'(i + 1 + s * 977);
        return p ^ (p >> 29);
    endfunction

    // Compare both ports against the model for their current addresses.
    task automatic cmp_ports(string req);
        int a = int'(rd_a_addr), b = int'(rd_b_addr);
        chk({req, " A data"}, rd_a_data, m_data[a]);
        chk({req, " A nan"}, 64'(rd_a_nan), 64'(m_nan[a]));
        chk({req, " A dirty"}, 64'(rd_a_dirty), 64'(m_dirty[a]));
        chk({req, " R5 A par"}, 64'(rd_a_par), 64'(^m_data[a]));
        chk({req, " R6 A perr"}, 64'(rd_a_perr), 64'd0);
        chk({req, " B data"}, rd_b_data, m_data[b]);
        chk({req, " B nan"}, 64'(rd_b_nan), 64'(m_nan[b]));
        chk({req, " B dirty"}, 64'(rd_b_dirty), 64'(m_dirty[b]));
        chk({req, " R5 B par"}, 64'(rd_b_par), 64'(^m_data[b]));
        chk({req, " R6 B perr"}, 64'(rd_b_perr), 64'd0);
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < NREG; i++) begin
            @(negedge clk);
            rd_a_addr = 7'(i);
            rd_b_addr = 7'(NREG - 1 - i);
            #1 cmp_ports(req);
        end
    endtask

    // Write one entry; check the old value is seen during the write cycle.
    task automatic do_write(int adr, logic [63:0] d, logic n);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'(adr); wr_data = d; wr_nan = n;
        rd_a_addr = 7'(adr);
        #1 chk("R3 old data", rd_a_data, m_data[adr]);
        @(negedge clk);
        wr_en = 1'b0;
        if (adr != 0) begin
            m_data[adr] = d; m_nan[adr] = n; m_dirty[adr] = 1'b1;
        end
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            m_data[i] = '0; m_nan[i] = 1'b0; m_dirty[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sweep("R1 reset");

        for (int i = 0; i < NREG; i++) do_write(i, pat(i, 0), (i % 5) == 0);
        sweep("R2 R4 R9 after writes");

        // R4: write to entry 0 must be ignored
        do_write(0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        @(negedge clk); rd_a_addr = '0; rd_b_addr = '0;
        #1 chk("R4 zero data", rd_a_data, 64'd0);
        chk("R4 zero nan", 64'(rd_b_nan), 64'd0);

        // R7: clear written flag on odd entries
        for (int i = 1; i < NREG; i += 2) begin
            @(negedge clk); clr_en = 1'b1; clr_addr = 7'(i);
            @(negedge clk); clr_en = 1'b0; m_dirty[i] = 1'b0;
        end
        sweep("R7 after clear");

        // R7: write and clear to the same entry, write wins
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'd9; wr_data = 64'h1; wr_nan = 1'b0;
        clr_en = 1'b1; clr_addr = 7'd9;
        @(negedge clk);
        wr_en = 1'b0; clr_en = 1'b0;
        m_data[9] = 64'h1; m_nan[9] = 1'b0; m_dirty[9] = 1'b1;
        rd_a_addr = 7'd9;
        #1 chk("R7 collision dirty", 64'(rd_a_dirty), 64'd1);
        chk("R5 odd parity word", 64'(rd_a_par), 64'd1);

        // R8: result invalid over many operand pairs
        for (int i = 0; i < NREG; i++) begin
            @(negedge clk);
            rd_a_addr = 7'(i);
            rd_b_addr = 7'((i * 37 + 11) % NREG);
            #1 chk("R8 res_nan", 64'(res_nan),
                   64'(m_nan[i] | m_nan[(i * 37 + 11) % NREG]));
        end

        // Second pattern with flipped invalid flags
        for (int i = 1; i < NREG; i++) do_write(i, pat(i, 1), (i % 3) == 1);
        sweep("R2 R9 second pattern");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule